// File: doc/BRIEF.md
# Super-I/O Configuration Port Controller

This block puts a small 8-bit configuration space behind a pair of I/O ports. Address bit 0 of a simple synchronous I/O bus selects the port: 0 is the index port and 1 is the data port. A host first writes a register number to the index port. It then reads or writes that register through the data port.

The configuration registers stay locked until the host writes an entry key to the index port. After unlocking, the space provides:

- fixed manufacturer, device and revision bytes;
- a logical-device number register;
- an activation bit and a 16-bit I/O base address for the one implemented logical device, the hardware monitor.

The activation bit and base address leave the block as plain outputs for a downstream address decoder. Any other logical-device number selects a placeholder that reads as zero.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, hw_enable_o is 0, hw_base_o is 0x0000, rdata_o is 0xFF, the block is locked and the logical-device number is 0x00.
- R2: While locked, reads of either port return 0xFF. Data-port writes are ignored, and hw_enable_o and hw_base_o do not change.
- R3: The block unlocks only after two consecutive index-port writes of 0x87. Any other index-port write between them discards the first one, so two fresh 0x87 writes are then needed.
- R4: While unlocked, an index-port write of 0xAA locks the block again.
- R5: While unlocked, index 0x20 reads 0x04 and index 0x21 reads 0x06 (device ID 0x0406, high byte at the lower index). Index 0x22 reads the revision byte, default 0x12. Index 0x23 reads 0x19 and index 0x24 reads 0x34 (manufacturer ID 0x1934, high byte first).
- R6: Index 0x07 is the logical-device number register. All 8 bits are written and read back.
- R7: Index 0x30 bit 0 is the activation bit of logical device 0x04 and drives hw_enable_o. Bits 7:1 read as 0.
- R8: Indices 0x60 and 0x61 hold the high and low bytes of the base address of device 0x04. hw_base_o presents the full 16-bit value.
- R9: While the logical-device number is not 0x04, indices 0x30, 0x60 and 0x61 read 0x00, and writes to them change nothing.
- R10: Every index-port write loads the index register, whether or not the block is locked. While unlocked, an index-port read returns the index and unlisted indices read 0x00. rdata_o changes only on the edge that samples rd_i high and holds between reads. A write takes effect on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | 0 = index port, 1 = data port |
| wr_i | input | 1 | Write strobe, one access per cycle high |
| rd_i | input | 1 | Read strobe, one access per cycle high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered on the read edge |
| hw_enable_o | output | 1 | Activation bit of the hardware-monitor device |
| hw_base_o | output | 16 | I/O base address of the hardware-monitor device |

## Verification
The hardest state to reach is an entry sequence broken partway through. A first 0x87 followed by an unrelated index write must leave the block locked even after the next 0x87. A clean pair of keys must still unlock it afterwards. Directed stimulus builds exactly that sequence.

A randomized phase then mixes key values, exit keys, logical-device changes and data writes. This produces writes while locked and while a foreign device is selected. A bench model that follows the requirements predicts every read and every output value.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int unsigned BASE_W = 16;

  localparam logic [7:0] ENTRY_KEY = 8'h87;
  localparam logic [7:0] EXIT_KEY  = 8'hAA;

  localparam logic [7:0] IX_LDN     = 8'h07;
  localparam logic [7:0] IX_DEV_HI  = 8'h20;
  localparam logic [7:0] IX_DEV_LO  = 8'h21;
  localparam logic [7:0] IX_REV     = 8'h22;
  localparam logic [7:0] IX_MFR_HI  = 8'h23;
  localparam logic [7:0] IX_MFR_LO  = 8'h24;
  localparam logic [7:0] IX_ACT     = 8'h30;
  localparam logic [7:0] IX_BASE_HI = 8'h60;
  localparam logic [7:0] IX_BASE_LO = 8'h61;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  typedef struct packed {
    logic       act_we;
    logic       base_hi_we;
    logic       base_lo_we;
    logic [7:0] wdata;
  } ldev_wr_t;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_we_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_we_i) begin
      unique case (state_q)
        KEY_LOCKED: state_d = (wdata_i == ENTRY_KEY) ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   state_d = (wdata_i == ENTRY_KEY) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   state_d = (wdata_i == EXIT_KEY)  ? KEY_LOCKED : KEY_OPEN;
        default:    state_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == KEY_OPEN);

  p_open_by_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(idx_we_i && wdata_i == ENTRY_KEY));

  p_half_abort_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KEY_HALF && idx_we_i && wdata_i != ENTRY_KEY) |=> !open_o);

  p_exit_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_we_i && wdata_i == EXIT_KEY) |=> !open_o);

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] LDN = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        sel_i,
  input  ldev_wr_t          wr_i,
  input  logic [7:0]        rd_idx_i,
  output logic [7:0]        rd_data_o,
  output logic              act_o,
  output logic [BASE_W-1:0] base_o
);

  localparam int unsigned HI_W = BASE_W - 8;

  logic              hit;
  logic              act_q;
  logic [BASE_W-1:0] base_q;

  assign hit = (sel_i == LDN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      base_q <= '0;
    end else if (hit) begin
      if (wr_i.act_we)     act_q             <= wr_i.wdata[0];
      if (wr_i.base_hi_we) base_q[BASE_W-1:8] <= wr_i.wdata[HI_W-1:0];
      if (wr_i.base_lo_we) base_q[7:0]       <= wr_i.wdata;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (hit) begin
      unique case (rd_idx_i)
        IX_ACT:     rd_data_o = {7'b0, act_q};
        IX_BASE_HI: rd_data_o = 8'(base_q[BASE_W-1:8]);
        IX_BASE_LO: rd_data_o = base_q[7:0];
        default:    rd_data_o = 8'h00;
      endcase
    end
  end

  assign act_o  = act_q;
  assign base_o = base_q;

  p_act_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit && wr_i.act_we) |=> $stable(act_o));

  p_base_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit && (wr_i.base_hi_we || wr_i.base_lo_we)) |=> $stable(base_o));

  p_foreign_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != LDN) |=> ($stable(base_o) && $stable(act_o)));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0406,
  parameter logic [15:0] MFR_ID  = 16'h1934,
  parameter logic [7:0]  DEV_REV = 8'h12,
  parameter logic [7:0]  HWM_LDN = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              hw_enable_o,
  output logic [BASE_W-1:0] hw_base_o
);

  logic       open;
  logic       idx_we, dat_we;
  logic [7:0] idx_q, ldn_q, rdata_q, rd_next, data_mux, bank_rd;
  ldev_wr_t   bank_wr;

  assign idx_we = wr_i && !addr_i;
  assign dat_we = wr_i && addr_i && open;

  sio_key_fsm u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_we_i (idx_we),
    .wdata_i  (wdata_i),
    .open_o   (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (idx_we) idx_q <= wdata_i;
      if (dat_we && idx_q == IX_LDN) ldn_q <= wdata_i;
    end
  end

  always_comb begin
    bank_wr.wdata      = wdata_i;
    bank_wr.act_we     = dat_we && (idx_q == IX_ACT);
    bank_wr.base_hi_we = dat_we && (idx_q == IX_BASE_HI);
    bank_wr.base_lo_we = dat_we && (idx_q == IX_BASE_LO);
  end

  sio_ldev_bank #(.LDN(HWM_LDN)) u_hwm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (ldn_q),
    .wr_i      (bank_wr),
    .rd_idx_i  (idx_q),
    .rd_data_o (bank_rd),
    .act_o     (hw_enable_o),
    .base_o    (hw_base_o)
  );

  always_comb begin
    unique case (idx_q)
      IX_LDN:    data_mux = ldn_q;
      IX_DEV_HI: data_mux = DEV_ID[15:8];
      IX_DEV_LO: data_mux = DEV_ID[7:0];
      IX_REV:    data_mux = DEV_REV;
      IX_MFR_HI: data_mux = MFR_ID[15:8];
      IX_MFR_LO: data_mux = MFR_ID[7:0];
      default:   data_mux = bank_rd;
    endcase
  end

  assign rd_next = !open ? 8'hFF : (addr_i ? data_mux : idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'hFF;
    else if (rd_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  p_locked_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !open) |=> (rdata_o == 8'hFF));

  p_locked_outs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open |=> ($stable(hw_enable_o) && $stable(hw_base_o)));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        hw_en;
  logic [15:0] hw_base;

  int n_chk = 0, n_fail = 0;

  bit          m_open = 0, m_half = 0, m_en = 0;
  logic [7:0]  m_idx = 0, m_sel = 0;
  logic [15:0] m_base = 0;

  always #4 clk = ~clk;

  sio_cfg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .hw_enable_o(hw_en), .hw_base_o(hw_base)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(bit a);
    if (!m_open) return 8'hFF;
    if (!a) return m_idx;
    case (m_idx)
      8'h07: return m_sel;
      8'h20: return 8'h04;
      8'h21: return 8'h06;
      8'h22: return 8'h12;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      8'h30: return (m_sel == 8'h04) ? {7'b0, m_en} : 8'h00;
      8'h60: return (m_sel == 8'h04) ? m_base[15:8] : 8'h00;
      8'h61: return (m_sel == 8'h04) ? m_base[7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(bit a, logic [7:0] d);
    if (!a) begin
      m_idx = d;
      if (m_open) begin
        if (d == 8'hAA) m_open = 0;
      end else if (d == 8'h87) begin
        if (m_half) begin m_open = 1; m_half = 0; end
        else m_half = 1;
      end else m_half = 0;
    end else if (m_open) begin
      case (m_idx)
        8'h07: m_sel = d;
        8'h30: if (m_sel == 8'h04) m_en = d[0];
        8'h60: if (m_sel == 8'h04) m_base[15:8] = d;
        8'h61: if (m_sel == 8'h04) m_base[7:0] = d;
        default: ;
      endcase
    end
  endfunction

  task automatic io_wr(bit a, logic [7:0] d);
    @(negedge clk); addr = a; wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic io_rd(bit a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(bit a, string req);
    logic [7:0] d;
    io_rd(a, d);
    chk(req, d, exp_rd(a));
  endtask

  task automatic out_chk(string req);
    chk({req, " hw_enable"}, hw_en, m_en);
    chk({req, " hw_base"}, hw_base, m_base);
  endtask

  function automatic logic [7:0] pick_idx(int k);
    case (k)
      0: return 8'h87; 1: return 8'hAA; 2: return 8'h07; 3: return 8'h20;
      4: return 8'h21; 5: return 8'h22; 6: return 8'h23; 7: return 8'h24;
      8: return 8'h30; 9: return 8'h60; 10: return 8'h61; default: return 8'h55;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 8'hFF);
    out_chk("R1");
    // R2 locked: reads FF, writes ignored
    rd_chk(1, "R2 locked data read");
    io_wr(0, 8'h30); io_wr(1, 8'h01);
    out_chk("R2 locked write");
    rd_chk(0, "R2 locked index read");
    // R3 interrupted key
    io_wr(0, 8'h87); io_wr(0, 8'h55); io_wr(0, 8'h87);
    rd_chk(1, "R3 interrupted key stays locked");
    io_wr(0, 8'h87);
    rd_chk(0, "R3 R10 unlocked index read");
    chk("R3 open", m_open, 1);
    // R5 identification
    for (int i = 0; i < 5; i++) begin
      io_wr(0, 8'h20 + 8'(i));
      rd_chk(1, "R5 id byte");
    end
    // R6 device number
    io_wr(0, 8'h07); io_wr(1, 8'hC3); rd_chk(1, "R6 ldn readback");
    io_wr(1, 8'h04); rd_chk(1, "R6 ldn readback");
    // R7 activation
    io_wr(0, 8'h30); io_wr(1, 8'hFF);
    rd_chk(1, "R7 activation read");
    chk("R7 hw_enable", hw_en, 1);
    // R8 base address
    io_wr(0, 8'h60); io_wr(1, 8'hA5);
    io_wr(0, 8'h61); io_wr(1, 8'h3C);
    chk("R8 hw_base", hw_base, 16'hA53C);
    rd_chk(1, "R8 base low read");
    io_wr(0, 8'h60); rd_chk(1, "R8 base high read");
    // R9 foreign device
    io_wr(0, 8'h07); io_wr(1, 8'h02);
    io_wr(0, 8'h60); rd_chk(1, "R9 foreign base read");
    io_wr(1, 8'h11);
    io_wr(0, 8'h30); rd_chk(1, "R9 foreign act read");
    io_wr(1, 8'h00);
    out_chk("R9 foreign write");
    io_wr(0, 8'h07); io_wr(1, 8'h04);
    io_wr(0, 8'h61); rd_chk(1, "R9 base kept");
    // R10 unlisted index, read hold
    io_wr(0, 8'h55); io_wr(1, 8'h99); rd_chk(1, "R10 unlisted index");
    io_wr(0, 8'h23); io_wr(1, 8'h00); rd_chk(1, "R10 read-only id");
    repeat (4) @(negedge clk);
    chk("R10 rdata hold", rdata, 8'h19);
    // R4 exit
    io_wr(0, 8'hAA);
    rd_chk(1, "R4 exit locks");
    io_wr(0, 8'h30); io_wr(1, 8'h00);
    out_chk("R4 R2 write after exit");

    // randomized phase
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom % 9;
      if (op < 3) io_wr(0, pick_idx($urandom % 13));
      else if (op < 5) begin
        if (m_idx == 8'h07 && ($urandom % 2)) d = 8'h04;
        else d = 8'($urandom);
        io_wr(1, d);
      end else if (op < 7) rd_chk(1, "R2 R5 R7 R8 R9 random data read");
      else if (op == 7) rd_chk(0, "R10 random index read");
      else begin
        io_wr(0, 8'h87); io_wr(0, 8'h87);
      end
      out_chk("R7 R8 random outputs");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule